// File: doc/BRIEF.md
# Ten-bit to eight-bit line code decoder with error flags

This block turns each received 10-bit line code group into a byte and a control-character flag. It tracks running disparity from word to word and reports two kinds of fault alongside the decoded byte: a code group that cannot occur at all, and a code group that is legal but arrives with the wrong disparity. A per-word bypass input skips decoding and delivers the raw code group with all decode outputs cleared.

Code groups enter on a valid/ready stream and leave on a second valid/ready stream through one output register. Back-pressure works like this: the block accepts a word when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value and no new word is taken. Comma detection and word alignment happen upstream.

Top module: `cg_decoder`

## Requirements
- R1: Input bit 0 is code bit a (first on the line) and bit 9 is code bit j (last). The 6-bit sub-block is bits 0..5 (a,b,c,d,e,i) and the 4-bit sub-block is bits 6..9 (f,g,h,j). `out_data` bits 0..4 carry the 5-bit value (A..E) and bits 5..7 the 3-bit value (F..H).
- R2: `out_k` is 1 for K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7, and 0 for data code groups.
- R3: After reset the running disparity is negative. On each decoded word it is updated from the received 6-bit sub-block and then the 4-bit sub-block. A sub-block with more ones than zeros makes it positive and one with fewer makes it negative. 000111 and 0011 make it positive, 111000 and 1100 make it negative, and any other balanced sub-block leaves it unchanged.
- R4: An invalid code group gives `out_err`=1, `out_disp_err`=0, `out_data`=0x00 and `out_k`=0. A code group is invalid if any of these holds: the 6-bit sub-block is not in the code set, or the 4-bit sub-block is 0000 or 1111.
- R5: A legal code group received against the current running disparity gives `out_err`=1 and `out_disp_err`=1, and `out_data` still carries the decoded byte.
- R6: A legal code group at the correct disparity gives `out_err`=0 and `out_disp_err`=0.
- R7: Outputs appear one cycle after acceptance. Byte, control flag, both error flags and the raw code group are aligned to the same word.
- R8: A word accepted with `in_byp`=1 produces zero data, zero control flag and zero error flags. The running disparity does not change.
- R9: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and all outputs stay constant.
- R10: Run-length rules on the x.7 sub-block. 1110 after e,i=11 is invalid, and 0001 after e,i=00 is invalid. The alternate forms 0111 and 1000 are legal only after e,i=11 and e,i=00 respectively, or after the 6-bit sub-block of x=23, 27, 28, 29 or 30. With K28, the forms 1110 and 0001 are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input code group present |
| in_ready | output | 1 | Block can take a code group |
| in_byp | input | 1 | Bypass decoding for this word |
| in_code | input | 10 | Received code group, bit 0 = a |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream can take the word |
| out_data | output | 8 | Decoded byte |
| out_k | output | 1 | Control-character flag |
| out_err | output | 1 | Any error on this word |
| out_disp_err | output | 1 | Error was a disparity error |
| out_raw | output | 10 | Accepted code group, undecoded |

## Verification
The assertions assume that `in_valid`, `in_byp`, `in_code` and `out_ready` carry known values and change only away from the rising edge. The stall check also assumes that the downstream side leaves `out_ready` low for as long as it means to stall. The bench meets this by driving every input on the falling edge and holding `in_code` steady while a word waits. The expected byte, flags and running disparity for each vector follow the order in which the words are sent from reset. The stimulus therefore always restarts from reset, or from a known disparity, before any run of dependent words.

// File: rtl/cg_dec_pkg.sv
package cg_dec_pkg;
  localparam int CG_W   = 10;
  localparam int SIX_W  = 6;
  localparam int FOUR_W = 4;
  localparam int X_W    = 5;
  localparam int Y_W    = 3;
  localparam int D_W    = X_W + Y_W;
  localparam int X_N    = 1 << X_W;

  // 6-bit sub-block properties; bit order inside s6 is a (MSB) .. i (LSB)
  typedef struct packed {
    logic [X_W-1:0] x;
    logic           hit;
    logic           k28;
    logic           kalt;
    logic           heavy;
    logic           light;
    logic           fpos;
    logic           fneg;
    logic [1:0]     ei;
  } six_info_t;

  // 4-bit sub-block properties; bit order f (MSB) .. j (LSB)
  typedef struct packed {
    logic [Y_W-1:0]    y;
    logic              ok;
    logic              heavy;
    logic              light;
    logic              fpos;
    logic              fneg;
    logic [FOUR_W-1:0] raw;
    logic [FOUR_W-1:0] inv;
  } four_info_t;

  // Negative-disparity 6-bit form of each 5-bit value
  function automatic logic [SIX_W-1:0] six_neg(input logic [X_W-1:0] v);
    logic [SIX_W-1:0] r;
    case (v)
      5'd0:  r = 6'b100111;  5'd1:  r = 6'b011101;
      5'd2:  r = 6'b101101;  5'd3:  r = 6'b110001;
      5'd4:  r = 6'b110101;  5'd5:  r = 6'b101001;
      5'd6:  r = 6'b011001;  5'd7:  r = 6'b111000;
      5'd8:  r = 6'b111001;  5'd9:  r = 6'b100101;
      5'd10: r = 6'b010101;  5'd11: r = 6'b110100;
      5'd12: r = 6'b001101;  5'd13: r = 6'b101100;
      5'd14: r = 6'b011100;  5'd15: r = 6'b010111;
      5'd16: r = 6'b011011;  5'd17: r = 6'b100011;
      5'd18: r = 6'b010011;  5'd19: r = 6'b110010;
      5'd20: r = 6'b001011;  5'd21: r = 6'b101010;
      5'd22: r = 6'b011010;  5'd23: r = 6'b111010;
      5'd24: r = 6'b110011;  5'd25: r = 6'b100110;
      5'd26: r = 6'b010110;  5'd27: r = 6'b110110;
      5'd28: r = 6'b001110;  5'd29: r = 6'b101110;
      5'd30: r = 6'b011110;  default: r = 6'b101011;
    endcase
    return r;
  endfunction

  // 3-bit value of a 4-bit sub-block given in negative-after-K28 orientation
  function automatic logic [Y_W-1:0] four_val(input logic [FOUR_W-1:0] f);
    logic [Y_W-1:0] r;
    case (f)
      4'b1011, 4'b0100: r = 3'd0;
      4'b1001:          r = 3'd1;
      4'b0101:          r = 3'd2;
      4'b1100, 4'b0011: r = 3'd3;
      4'b1101, 4'b0010: r = 3'd4;
      4'b1010:          r = 3'd5;
      4'b0110:          r = 3'd6;
      default:          r = 3'd7;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cg_six_unit.sv
module cg_six_unit
  import cg_dec_pkg::*;
(
  input  logic [SIX_W-1:0] s6,
  output six_info_t        info
);
  localparam logic [SIX_W-1:0] K28_NEG = 6'b001111;
  localparam int               HALF    = SIX_W / 2;

  logic [2:0]       ones;
  logic [SIX_W-1:0] key;
  logic             thit;
  logic [X_W-1:0]   idx;
  logic             is_k28;

  always_comb begin
    ones = 3'($countones(s6));
    // positive-disparity forms are the complement of the stored negative form
    key  = ((ones < 3'(HALF)) || (s6 == 6'b000111)) ? ~s6 : s6;
    thit = 1'b0;
    idx  = '0;
    for (int i = 0; i < X_N; i++) begin
      if (six_neg(X_W'(i)) == key) begin
        thit = 1'b1;
        idx  = X_W'(i);
      end
    end
    is_k28 = (key == K28_NEG);

    info.k28   = is_k28;
    info.hit   = thit || is_k28;
    info.x     = is_k28 ? 5'd28 : idx;
    info.kalt  = is_k28 || (thit && ((idx == 5'd23) || (idx == 5'd27) ||
                                     (idx == 5'd29) || (idx == 5'd30)));
    info.heavy = ones > 3'(HALF);
    info.light = ones < 3'(HALF);
    info.fpos  = (s6 == 6'b000111);
    info.fneg  = (s6 == 6'b111000);
    info.ei    = s6[1:0];
  end
endmodule

// File: rtl/cg_four_unit.sv
module cg_four_unit
  import cg_dec_pkg::*;
(
  input  logic [FOUR_W-1:0] f4,
  input  logic              flip,
  output four_info_t        info
);
  localparam int HALF = FOUR_W / 2;

  logic [2:0]        ones;
  logic [FOUR_W-1:0] oriented;

  always_comb begin
    ones       = 3'($countones(f4));
    oriented   = f4 ^ {FOUR_W{flip}};
    info.raw   = f4;
    info.inv   = oriented;
    info.y     = four_val(oriented);
    info.ok    = (ones >= 3'(HALF - 1)) && (ones <= 3'(HALF + 1));
    info.heavy = ones > 3'(HALF);
    info.light = ones < 3'(HALF);
    info.fpos  = (f4 == 4'b0011);
    info.fneg  = (f4 == 4'b1100);
  end
endmodule

// File: rtl/cg_rules_unit.sv
module cg_rules_unit
  import cg_dec_pkg::*;
(
  input  logic           rd_in,
  input  six_info_t      six,
  input  four_info_t     four,
  output logic [D_W-1:0] data,
  output logic           is_k,
  output logic           err,
  output logic           disp_err,
  output logic           rd_out
);
  logic rd_mid, bad6, bad4, run_bad, bad_code, a7;

  always_comb begin
    // running disparity walk: 6-bit first, then 4-bit
    rd_mid = six.heavy ? 1'b1 : six.light ? 1'b0 :
             six.fpos  ? 1'b1 : six.fneg  ? 1'b0 : rd_in;
    rd_out = four.heavy ? 1'b1 : four.light ? 1'b0 :
             four.fpos  ? 1'b1 : four.fneg  ? 1'b0 : rd_mid;

    bad6 = (six.heavy && rd_in) || (six.light && !rd_in) ||
           (six.fpos && !rd_in) || (six.fneg && rd_in);
    bad4 = (four.heavy && rd_mid) || (four.light && !rd_mid) ||
           (four.fpos && !rd_mid) || (four.fneg && rd_mid);

    a7 = (four.raw == 4'b0111) || (four.raw == 4'b1000);
    run_bad = ((four.raw == 4'b1110) && (six.ei == 2'b11)) ||
              ((four.raw == 4'b0001) && (six.ei == 2'b00)) ||
              ((four.raw == 4'b0111) && (six.ei != 2'b11) && !six.kalt) ||
              ((four.raw == 4'b1000) && (six.ei != 2'b00) && !six.kalt) ||
              (six.k28 && ((four.inv == 4'b0001) || (four.inv == 4'b1110)));

    bad_code = !six.hit || !four.ok || run_bad;
    err      = bad_code || bad6 || bad4;
    disp_err = !bad_code && (bad6 || bad4);
    is_k     = !bad_code && (six.k28 || (six.kalt && a7));
    data     = bad_code ? '0 : {four.y, six.x};
  end
endmodule

// File: rtl/cg_decoder.sv
module cg_decoder
  import cg_dec_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_byp,
  input  logic [CG_W-1:0] in_code,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [D_W-1:0]  out_data,
  output logic            out_k,
  output logic            out_err,
  output logic            out_disp_err,
  output logic [CG_W-1:0] out_raw
);
  logic [SIX_W-1:0]  s6;
  logic [FOUR_W-1:0] f4;
  six_info_t         six;
  four_info_t        four;
  logic [D_W-1:0]    dec_data;
  logic              dec_k, dec_err, dec_disp, rd_next;
  logic              rd_q;
  logic              take;

  // first-received bit becomes the MSB of each sub-block
  always_comb begin
    for (int i = 0; i < SIX_W; i++)  s6[SIX_W-1-i]  = in_code[i];
    for (int i = 0; i < FOUR_W; i++) f4[FOUR_W-1-i] = in_code[SIX_W+i];
  end

  cg_six_unit six_i (.s6(s6), .info(six));

  cg_four_unit four_i (
    .f4   (f4),
    .flip (six.k28 && six.light),
    .info (four)
  );

  cg_rules_unit rules_i (
    .rd_in    (rd_q),
    .six      (six),
    .four     (four),
    .data     (dec_data),
    .is_k     (dec_k),
    .err      (dec_err),
    .disp_err (dec_disp),
    .rd_out   (rd_next)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_k        <= 1'b0;
      out_err      <= 1'b0;
      out_disp_err <= 1'b0;
      out_raw      <= '0;
      rd_q         <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_raw   <= in_code;
      if (in_byp) begin
        out_data     <= '0;
        out_k        <= 1'b0;
        out_err      <= 1'b0;
        out_disp_err <= 1'b0;
      end else begin
        out_data     <= dec_data;
        out_k        <= dec_k;
        out_err      <= dec_err;
        out_disp_err <= dec_disp;
        rd_q         <= rd_next;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cg_decoder_chk.sv
module cg_decoder_chk
  import cg_dec_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            in_byp,
  input logic [CG_W-1:0] in_code,
  input logic            out_valid,
  input logic            out_ready,
  input logic [D_W-1:0]  out_data,
  input logic            out_k,
  input logic            out_err,
  input logic            out_disp_err,
  input logic [CG_W-1:0] out_raw
);
  p_flag_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_disp_err |-> out_err);

  p_invalid_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err && !out_disp_err |-> (out_data == '0) && !out_k);

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && (out_raw == $past(in_code)));

  p_bypass_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_byp |=>
      !out_err && !out_disp_err && !out_k && (out_data == '0));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=>
      out_valid && $stable(out_raw) && $stable(out_data) &&
      $stable(out_err) && $stable(out_disp_err) && $stable(out_k));
endmodule

bind cg_decoder cg_decoder_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_byp       (in_byp),
  .in_code      (in_code),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .out_k        (out_k),
  .out_err      (out_err),
  .out_disp_err (out_disp_err),
  .out_raw      (out_raw)
);

// File: tb/cg_decoder_tb_top.sv
module cg_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_byp = 1'b0;
  logic [9:0] in_code = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_k, out_err, out_disp_err;
  logic [9:0] out_raw;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cg_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byp(in_byp), .in_code(in_code), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_k(out_k),
    .out_err(out_err), .out_disp_err(out_disp_err), .out_raw(out_raw)
  );

  // {bypass, code in line order a..j written left to right, byte, k, err, disp}
  localparam int NV = 22;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 10'b0011111010, 8'hBC, 1'b1, 1'b0, 1'b0},
    {1'b0, 10'b1010101010, 8'hB5, 1'b0, 1'b0, 1'b0},
    {1'b0, 10'b1100000101, 8'hBC, 1'b1, 1'b0, 1'b0},
    {1'b0, 10'b1001110100, 8'h00, 1'b0, 1'b0, 1'b0},
    {1'b0, 10'b1100011100, 8'h63, 1'b0, 1'b0, 1'b0},
    {1'b0, 10'b1110001110, 8'hE7, 1'b0, 1'b0, 1'b0},
    {1'b0, 10'b0001110100, 8'h07, 1'b0, 1'b0, 1'b0},
    {1'b0, 10'b1000110111, 8'hF1, 1'b0, 1'b0, 1'b0},
    {1'b0, 10'b0001010111, 8'hF7, 1'b1, 1'b0, 1'b0},
    {1'b0, 10'b1100000111, 8'hFC, 1'b1, 1'b0, 1'b0},
    {1'b0, 10'b1101001000, 8'hEB, 1'b0, 1'b0, 1'b0},
    {1'b0, 10'b1111001010, 8'h00, 1'b0, 1'b1, 1'b0},
    {1'b0, 10'b0111010100, 8'h01, 1'b0, 1'b1, 1'b1},
    {1'b0, 10'b1010101111, 8'h00, 1'b0, 1'b1, 1'b0},
    {1'b0, 10'b1101000001, 8'h00, 1'b0, 1'b1, 1'b0},
    {1'b1, 10'b0011111010, 8'h00, 1'b0, 1'b0, 1'b0},
    {1'b1, 10'b1111111111, 8'h00, 1'b0, 1'b0, 1'b0},
    {1'b0, 10'b0011111010, 8'hBC, 1'b1, 1'b0, 1'b0},
    {1'b0, 10'b1010101100, 8'h75, 1'b0, 1'b1, 1'b1},
    {1'b0, 10'b0001110100, 8'h07, 1'b0, 1'b1, 1'b1},
    {1'b0, 10'b0011111001, 8'h3C, 1'b1, 1'b0, 1'b0},
    {1'b0, 10'b1100000110, 8'h3C, 1'b1, 1'b0, 1'b0}
  };

  function automatic string vec_req(input int i);
    case (i)
      0, 2, 8, 9, 20, 21: return "R2";
      1, 4:               return "R1";
      3:                  return "R6";
      5, 6:               return "R3";
      7, 10, 14:          return "R10";
      11, 13:             return "R4";
      12, 18, 19:         return "R5";
      default:            return "R8";
    endcase
  endfunction

  // line-order literal to port order: leftmost (a) lands on bit 0
  function automatic logic [9:0] ord(input logic [9:0] n);
    logic [9:0] r;
    for (int i = 0; i < 10; i++) r[i] = n[9-i];
    return r;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic byp, input logic [9:0] code_n);
    @(negedge clk);
    in_valid = 1'b1;
    in_byp   = byp;
    in_code  = ord(code_n);
    @(negedge clk);
    in_valid = 1'b0;
    in_byp   = 1'b0;
  endtask

  task automatic check_word(input string req, input logic [9:0] code_n,
                            input logic [7:0] d, input logic k,
                            input logic e, input logic de);
    chk(req, "out_valid", 32'(out_valid), 32'd1);
    chk(req, "out_raw", 32'(out_raw), 32'(ord(code_n)));
    chk(req, "out_data", 32'(out_data), 32'(d));
    chk(req, "out_k", 32'(out_k), 32'(k));
    chk(req, "out_err", 32'(out_err), 32'(e));
    chk(req, "out_disp_err", 32'(out_disp_err), 32'(de));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // reset state (R7, R9)
    repeat (2) @(negedge clk);
    chk("R7", "out_valid in reset", 32'(out_valid), 32'd0);
    chk("R9", "in_ready in reset", 32'(in_ready), 32'd1);
    chk("R6", "out_err in reset", 32'(out_err), 32'd0);
    rst_n = 1'b1;

    // vector walk; disparity starts negative (R3)
    for (int i = 0; i < NV; i++) begin
      push(VEC[i][21], VEC[i][20:11]);
      check_word(vec_req(i), VEC[i][20:11], VEC[i][10:3],
                 VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // output empties when nothing new arrives (R7)
    @(negedge clk);
    chk("R7", "out_valid idle", 32'(out_valid), 32'd0);

    // stall: disparity is negative here; K28.5 neg-form then pos-form (R9)
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_code   = ord(10'b0011111010);
    @(negedge clk);
    chk("R9", "in_ready stalled", 32'(in_ready), 32'd0);
    chk("R9", "out_raw first", 32'(out_raw), 32'(ord(10'b0011111010)));
    in_code = ord(10'b1100000101);
    @(negedge clk);
    chk("R9", "out_valid held", 32'(out_valid), 32'd1);
    chk("R9", "out_raw held", 32'(out_raw), 32'(ord(10'b0011111010)));
    chk("R9", "out_data held", 32'(out_data), 32'h0BC);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_word("R9", 10'b1100000101, 8'hBC, 1'b1, 1'b0, 1'b0);

    // reset mid-stream returns disparity to negative (R3)
    push(1'b0, 10'b0011111010);
    check_word("R3", 10'b0011111010, 8'hBC, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R7", "out_valid after reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    push(1'b0, 10'b0011111010);
    check_word("R3", 10'b0011111010, 8'hBC, 1'b1, 1'b0, 1'b0);

    // without reset the same neg-form word now arrives at positive disparity (R5)
    push(1'b0, 10'b0011111010);
    check_word("R5", 10'b0011111010, 8'hBC, 1'b1, 1'b1, 1'b1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule